// File: doc/BRIEF.md
# MSI Capture Ring-Buffer Controller

This block receives message-signalled interrupt words on a valid/ready port and stores each as a 16-byte record in a ring buffer in system memory. It issues one 128-bit write per record on a memory write master port. Software sets the ring's 64-bit base and its size, and enables the controller, through a small word-addressed register port. Software then drains the ring by reading records between its read offset and the hardware write offset, and advances the read offset by writing it back.

The block keeps a level interrupt asserted while unread records remain. Full detection is optional. When the ring is full, the block either back-pressures the message source or drops the message and records a sticky overflow flag. Which of the two it does is chosen by a control bit.

Top module: `msi_ring_ctrl`

## Requirements
- R1: Register word addresses are: control at 0, base high at 3, base low at 4, read offset at 5 and write offset at 6. The write offset is read-only, and every other address reads as zero. In the control register, bit 0 is enable, bit 1 is full detection, bit 3 is interrupt enable, bit 4 is stop-on-full and bits 9:8 are the size field. All other bits read back as zero, except bit 31. Bit 31 reads as the overflow flag, and writing 1 to it clears the flag.
- R2: A synchronous active-high reset clears every register to zero, so irq and msi_ready are low.
- R3: Size field s gives a ring of 2^(s+15) bytes. Offsets are masked with (size-1) and have their low 4 bits cleared, including a read offset written by software, which is masked with the size in force when it is written.
- R4: Each record is written to {base_hi, base_lo} plus the write offset. Its 32-bit vector sits in mem_data[31:0] (the first four bytes, little-endian) and mem_data[127:32] is zero.
- R5: The write offset advances by 16, wrapping at the ring size, only in the cycle after the memory write handshake (mem_valid and mem_ready both high) completes.
- R6: The ring is full when full detection is on and (write offset + 16) masked equals the read offset. With stop-on-full set, msi_ready is low while the ring is full.
- R7: With full detection on and stop-on-full clear, a message arriving at a full ring is accepted, no memory write is issued, the write offset is unchanged and the overflow flag (control bit 31) is set. If a clear and a set fall in the same cycle, the set wins.
- R8: At most one memory write is outstanding. msi_ready is low while mem_valid is high, and mem_addr and mem_data hold steady until mem_ready.
- R9: While enable is clear, msi_ready is low and no memory write is started.
- R10: irq is high exactly when interrupt enable is set and the read offset differs from the write offset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | 3 | Register word address |
| reg_we | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| msi_valid | input | 1 | Inbound message valid |
| msi_ready | output | 1 | Inbound message ready |
| msi_data | input | 32 | Inbound vector word |
| mem_valid | output | 1 | Memory write request valid |
| mem_ready | input | 1 | Memory write accepted |
| mem_addr | output | 64 | Memory write byte address |
| mem_data | output | 128 | Memory write record |
| irq | output | 1 | Level interrupt to host |

## Verification
A software write to the read offset can land in the same cycle as a memory handshake that moves the write offset. A write of 1 to the overflow bit can land in the same cycle as an overflowing message that sets it. The bench provokes both by issuing register writes while messages are streaming into a full ring. The reference model updates both offsets and the flag from the same pre-edge state, and compares irq, msi_ready and every register read against the design on every clock. The model also lets the flag's set win over its clear, so a design that orders these updates wrongly disagrees with the model in the cycle that follows.

// File: rtl/msi_ring_pkg.sv
package msi_ring_pkg;

    localparam int REG_AW        = 3;
    localparam int REG_DW        = 32;
    localparam int OFF_W         = 32;
    localparam int MEM_AW        = 64;
    localparam int MEM_DW        = 128;
    localparam int MSG_W         = 32;
    localparam int ENTRY_BYTES   = 16;
    localparam int SIZE_EXP_BASE = 15;
    localparam int SIZE_SEL_W    = 2;

    // register word addresses
    localparam logic [REG_AW-1:0] RA_CTRL    = 3'd0;
    localparam logic [REG_AW-1:0] RA_BASE_HI = 3'd3;
    localparam logic [REG_AW-1:0] RA_BASE_LO = 3'd4;
    localparam logic [REG_AW-1:0] RA_RD_OFF  = 3'd5;
    localparam logic [REG_AW-1:0] RA_WR_OFF  = 3'd6;

    // control bit positions
    localparam int CB_EN      = 0;
    localparam int CB_FULL    = 1;
    localparam int CB_IRQ     = 3;
    localparam int CB_STOP    = 4;
    localparam int CB_SIZE_LO = 8;
    localparam int CB_OVF     = 31;

    typedef struct packed {
        logic [SIZE_SEL_W-1:0] size_sel;
        logic                  stop_on_full;
        logic                  irq_en;
        logic                  full_det;
        logic                  enable;
    } ctrl_t;

    typedef struct packed {
        logic [MEM_AW-1:0] addr;
        logic [MEM_DW-1:0] data;
    } mem_req_t;

    // byte mask keeping an offset inside the ring and on a record boundary
    function automatic logic [OFF_W-1:0] ring_mask(input logic [SIZE_SEL_W-1:0] sel);
        logic [OFF_W-1:0] m;
        m = (OFF_W'(1) << (SIZE_EXP_BASE + int'(sel))) - OFF_W'(1);
        m = m & ~OFF_W'(ENTRY_BYTES - 1);
        return m;
    endfunction

    function automatic logic [OFF_W-1:0] next_off(input logic [OFF_W-1:0] off,
                                                  input logic [OFF_W-1:0] mask);
        return (off + OFF_W'(ENTRY_BYTES)) & mask;
    endfunction

    // record layout: vector in the first (lowest) four bytes, rest zero
    function automatic logic [MEM_DW-1:0] pack_entry(input logic [MSG_W-1:0] vec);
        return MEM_DW'(vec);
    endfunction

endpackage

// File: rtl/msi_ring_regs.sv
module msi_ring_regs
    import msi_ring_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic              reg_we,
    input  logic [REG_DW-1:0] reg_wdata,
    output logic [REG_DW-1:0] reg_rdata,
    input  logic [OFF_W-1:0]  wr_off,
    input  logic              ovf_set,
    output ctrl_t             ctrl,
    output logic [MEM_AW-1:0] base,
    output logic [OFF_W-1:0]  rd_off,
    output logic [OFF_W-1:0]  mask
);

    localparam int HALF_AW = MEM_AW / 2;

    logic [HALF_AW-1:0] base_hi_q;
    logic [HALF_AW-1:0] base_lo_q;
    logic               ovf_q;
    logic [REG_DW-1:0]  ctrl_word;

    assign base = {base_hi_q, base_lo_q};
    assign mask = ring_mask(ctrl.size_sel);

    always_comb begin
        ctrl_word                                   = '0;
        ctrl_word[CB_EN]                            = ctrl.enable;
        ctrl_word[CB_FULL]                          = ctrl.full_det;
        ctrl_word[CB_IRQ]                           = ctrl.irq_en;
        ctrl_word[CB_STOP]                          = ctrl.stop_on_full;
        ctrl_word[CB_SIZE_LO +: SIZE_SEL_W]         = ctrl.size_sel;
        ctrl_word[CB_OVF]                           = ovf_q;
    end

    always_comb begin
        case (reg_addr)
            RA_CTRL:    reg_rdata = ctrl_word;
            RA_BASE_HI: reg_rdata = REG_DW'(base_hi_q);
            RA_BASE_LO: reg_rdata = REG_DW'(base_lo_q);
            RA_RD_OFF:  reg_rdata = REG_DW'(rd_off);
            RA_WR_OFF:  reg_rdata = REG_DW'(wr_off);
            default:    reg_rdata = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl      <= '0;
            base_hi_q <= '0;
            base_lo_q <= '0;
            rd_off    <= '0;
        end else if (reg_we) begin
            case (reg_addr)
                RA_CTRL: begin
                    ctrl.enable       <= reg_wdata[CB_EN];
                    ctrl.full_det     <= reg_wdata[CB_FULL];
                    ctrl.irq_en       <= reg_wdata[CB_IRQ];
                    ctrl.stop_on_full <= reg_wdata[CB_STOP];
                    ctrl.size_sel     <= reg_wdata[CB_SIZE_LO +: SIZE_SEL_W];
                end
                RA_BASE_HI: base_hi_q <= reg_wdata[HALF_AW-1:0];
                RA_BASE_LO: base_lo_q <= reg_wdata[HALF_AW-1:0];
                RA_RD_OFF:  rd_off    <= OFF_W'(reg_wdata) & mask;
                default: ;
            endcase
        end
    end

    // sticky overflow: a new event wins over a simultaneous clear
    always_ff @(posedge clk) begin
        if (rst) begin
            ovf_q <= 1'b0;
        end else if (ovf_set) begin
            ovf_q <= 1'b1;
        end else if (reg_we && reg_addr == RA_CTRL && reg_wdata[CB_OVF]) begin
            ovf_q <= 1'b0;
        end
    end

endmodule

// File: rtl/msi_ring_writer.sv
module msi_ring_writer
    import msi_ring_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  ctrl_t             ctrl,
    input  logic [OFF_W-1:0]  mask,
    input  logic [MEM_AW-1:0] base,
    input  logic [OFF_W-1:0]  rd_off,
    input  logic              msi_valid,
    output logic              msi_ready,
    input  logic [MSG_W-1:0]  msi_data,
    output logic              mem_valid,
    input  logic              mem_ready,
    output logic [MEM_AW-1:0] mem_addr,
    output logic [MEM_DW-1:0] mem_data,
    output logic [OFF_W-1:0]  wr_off,
    output logic              ring_full,
    output logic              ovf_set
);

    mem_req_t req_q;
    logic     pend_q;
    logic     accept;
    logic     store;

    assign ring_full = ctrl.full_det && (next_off(wr_off, mask) == rd_off);
    assign msi_ready = ctrl.enable && !pend_q && !(ring_full && ctrl.stop_on_full);
    assign accept    = msi_valid && msi_ready;
    assign store     = accept && !ring_full;
    assign ovf_set   = accept && ring_full;

    assign mem_valid = pend_q;
    assign mem_addr  = req_q.addr;
    assign mem_data  = req_q.data;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q <= 1'b0;
            req_q  <= '0;
            wr_off <= '0;
        end else if (store) begin
            pend_q     <= 1'b1;
            req_q.addr <= base + MEM_AW'(wr_off);
            req_q.data <= pack_entry(msi_data);
        end else if (pend_q && mem_ready) begin
            pend_q <= 1'b0;
            wr_off <= next_off(wr_off, mask);
        end
    end

endmodule

// File: rtl/msi_ring_ctrl.sv
module msi_ring_ctrl
    import msi_ring_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic [2:0]          reg_addr,
    input  logic                reg_we,
    input  logic [31:0]         reg_wdata,
    output logic [31:0]         reg_rdata,
    input  logic                msi_valid,
    output logic                msi_ready,
    input  logic [31:0]         msi_data,
    output logic                mem_valid,
    input  logic                mem_ready,
    output logic [63:0]         mem_addr,
    output logic [127:0]        mem_data,
    output logic                irq
);

    ctrl_t             ctrl_q;
    logic [MEM_AW-1:0] base;
    logic [OFF_W-1:0]  rd_off;
    logic [OFF_W-1:0]  wr_off;
    logic [OFF_W-1:0]  mask;
    logic              ring_full;
    logic              ovf_set;

    msi_ring_regs i_regs (
        .clk       (clk),
        .rst       (rst),
        .reg_addr  (reg_addr),
        .reg_we    (reg_we),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .wr_off    (wr_off),
        .ovf_set   (ovf_set),
        .ctrl      (ctrl_q),
        .base      (base),
        .rd_off    (rd_off),
        .mask      (mask)
    );

    msi_ring_writer i_writer (
        .clk       (clk),
        .rst       (rst),
        .ctrl      (ctrl_q),
        .mask      (mask),
        .base      (base),
        .rd_off    (rd_off),
        .msi_valid (msi_valid),
        .msi_ready (msi_ready),
        .msi_data  (msi_data),
        .mem_valid (mem_valid),
        .mem_ready (mem_ready),
        .mem_addr  (mem_addr),
        .mem_data  (mem_data),
        .wr_off    (wr_off),
        .ring_full (ring_full),
        .ovf_set   (ovf_set)
    );

    assign irq = ctrl_q.irq_en && (rd_off != wr_off);

endmodule

// File: rtl/msi_ring_chk.sv
module msi_ring_chk (
    input logic         clk,
    input logic         rst,
    input logic         msi_ready,
    input logic         mem_valid,
    input logic         mem_ready,
    input logic [63:0]  mem_addr,
    input logic [127:0] mem_data,
    input logic         en,
    input logic         stop,
    input logic         ring_full,
    input logic [31:0]  wr_off
);

    a_r8_hold_request: assert property (@(posedge clk) disable iff (rst)
        (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr) && $stable(mem_data)));

    a_r8_single_outstanding: assert property (@(posedge clk) disable iff (rst)
        mem_valid |-> !msi_ready);

    a_r5_woff_on_handshake: assert property (@(posedge clk) disable iff (rst)
        !(mem_valid && mem_ready) |=> $stable(wr_off));

    a_r9_disabled_blocks: assert property (@(posedge clk) disable iff (rst)
        !en |-> !msi_ready);

    a_r6_stop_on_full: assert property (@(posedge clk) disable iff (rst)
        (stop && ring_full) |-> !msi_ready);

    a_r4_upper_zero: assert property (@(posedge clk) disable iff (rst)
        mem_valid |-> (mem_data[127:32] == '0));

    a_r3_aligned: assert property (@(posedge clk) disable iff (rst)
        wr_off[3:0] == 4'd0);

endmodule

bind msi_ring_ctrl msi_ring_chk i_chk (
    .clk       (clk),
    .rst       (rst),
    .msi_ready (msi_ready),
    .mem_valid (mem_valid),
    .mem_ready (mem_ready),
    .mem_addr  (mem_addr),
    .mem_data  (mem_data),
    .en        (ctrl_q.enable),
    .stop      (ctrl_q.stop_on_full),
    .ring_full (ring_full),
    .wr_off    (wr_off)
);

// File: tb/test_msi_ring_ctrl.sv
module test_msi_ring_ctrl;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [2:0]   reg_addr = '0;
    logic         reg_we = 1'b0;
    logic [31:0]  reg_wdata = '0;
    logic [31:0]  reg_rdata;
    logic         msi_valid = 1'b0;
    logic         msi_ready;
    logic [31:0]  msi_data = '0;
    logic         mem_valid;
    logic         mem_ready = 1'b1;
    logic [63:0]  mem_addr;
    logic [127:0] mem_data;
    logic         irq;

    int n_total = 0;
    int n_fail  = 0;
    int cyc     = 0;
    bit stall   = 1'b0;
    bit started = 1'b0;

    // reference model state
    logic [31:0]  m_ctrl, m_hi, m_lo, m_roff, m_woff;
    logic         m_ovf, m_busy;
    logic [63:0]  m_addr;
    logic [31:0]  m_vec;
    logic [31:0]  written[$];

    always #10 clk = ~clk;

    msi_ring_ctrl i_msi_ring_ctrl (
        .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_we(reg_we),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .msi_valid(msi_valid),
        .msi_ready(msi_ready), .msi_data(msi_data), .mem_valid(mem_valid),
        .mem_ready(mem_ready), .mem_addr(mem_addr), .mem_data(mem_data), .irq(irq)
    );

    function automatic logic [31:0] m_mask(input logic [1:0] s);
        return ((32'h8000 << s) - 32'd1) & 32'hFFFF_FFF0;
    endfunction

    function automatic bit m_full();
        return m_ctrl[1] && (((m_woff + 32'd16) & m_mask(m_ctrl[9:8])) == m_roff);
    endfunction

    function automatic bit m_ready();
        return m_ctrl[0] && !m_busy && !(m_full() && m_ctrl[4]);
    endfunction

    function automatic logic [31:0] m_rdata(input logic [2:0] a);
        case (a)
            3'd0:    return m_ctrl | {m_ovf, 31'd0};
            3'd3:    return m_hi;
            3'd4:    return m_lo;
            3'd5:    return m_roff;
            3'd6:    return m_woff;
            default: return 32'd0;
        endcase
    endfunction

    task automatic chk(input bit ok, input string what,
                       input logic [127:0] act, input logic [127:0] exp);
        n_total++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_total - n_fail, n_total);
    endtask

    // model update, from the same pre-edge state the design sees
    always @(posedge clk) begin
        cyc++;
        if (rst) begin
            m_ctrl = 0; m_hi = 0; m_lo = 0; m_roff = 0; m_woff = 0;
            m_ovf = 0; m_busy = 0; m_addr = 0; m_vec = 0;
            started = 1'b1;
        end else begin
            bit          full, acc;
            logic [31:0] mk;
            full = m_full();
            acc  = msi_valid && m_ready();
            mk   = m_mask(m_ctrl[9:8]);
            if (m_busy && mem_ready) begin
                written.push_back(m_vec);
                m_woff = (m_woff + 32'd16) & mk;
                m_busy = 1'b0;
            end else if (acc && !full) begin
                m_busy = 1'b1;
                m_addr = {m_hi, m_lo} + 64'(m_woff);
                m_vec  = msi_data;
            end
            if (reg_we && reg_addr == 3'd0 && reg_wdata[31]) m_ovf = 1'b0;
            if (acc && full) m_ovf = 1'b1;
            if (reg_we) begin
                case (reg_addr)
                    3'd0: m_ctrl = reg_wdata & 32'h0000_031B;
                    3'd3: m_hi   = reg_wdata;
                    3'd4: m_lo   = reg_wdata;
                    3'd5: m_roff = reg_wdata & mk;
                    default: ;
                endcase
            end
        end
        if (cyc == 100000) begin
            n_total++; n_fail++;
            $display("FAIL watchdog expired actual=%0d expected<%0d", cyc, 100000);
            summary();
            $finish;
        end
    end

    // per-clock comparison, away from the active edge
    always @(negedge clk) begin
        #2;
        if (started && !rst) begin
            chk(msi_ready == m_ready(), "R6 R8 R9 msi_ready", 128'(msi_ready), 128'(m_ready()));
            chk(mem_valid == m_busy, "R8 mem_valid", 128'(mem_valid), 128'(m_busy));
            if (m_busy) begin
                chk(mem_addr == m_addr, "R4 mem_addr", 128'(mem_addr), 128'(m_addr));
                chk(mem_data == 128'(m_vec), "R4 mem_data", mem_data, 128'(m_vec));
            end
            chk(irq == (m_ctrl[3] && m_roff != m_woff), "R10 irq",
                128'(irq), 128'(m_ctrl[3] && m_roff != m_woff));
            chk(reg_rdata == m_rdata(reg_addr), "R1 reg_rdata",
                128'(reg_rdata), 128'(m_rdata(reg_addr)));
        end
    end

    always @(negedge clk) mem_ready = stall ? (cyc % 3 == 0) : 1'b1;

    task automatic reg_wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_addr = a; reg_we = 1'b1; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic reg_expect(input logic [2:0] a, input logic [31:0] exp, input string tag);
        @(negedge clk);
        reg_addr = a;
        #3;
        chk(reg_rdata == exp, tag, 128'(reg_rdata), 128'(exp));
    endtask

    task automatic send(input logic [31:0] d, input int max_wait, output bit took);
        @(negedge clk);
        msi_valid = 1'b1; msi_data = d; took = 1'b0;
        for (int i = 0; i < max_wait; i++) begin
            #1;
            if (msi_ready) begin
                took = 1'b1;
                @(negedge clk);
                break;
            end
            @(negedge clk);
        end
        msi_valid = 1'b0;
    endtask

    initial begin
        bit took;
        int n_ok;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R2: everything zero after reset
        reg_expect(3'd0, 32'd0, "R2 ctrl after reset");
        reg_expect(3'd3, 32'd0, "R2 base_hi after reset");
        reg_expect(3'd4, 32'd0, "R2 base_lo after reset");
        reg_expect(3'd5, 32'd0, "R2 rd_off after reset");
        reg_expect(3'd6, 32'd0, "R2 wr_off after reset");
        chk(!irq && !msi_ready, "R2 irq/ready after reset", 128'({irq, msi_ready}), 128'(0));

        // R9: disabled controller never accepts
        send(32'h11, 6, took);
        chk(!took, "R9 accepted while disabled", 128'(took), 128'(0));

        // R4 R5: basic capture with memory stalls
        reg_wr(3'd3, 32'h0000_0001);
        reg_wr(3'd4, 32'h8000_0000);
        reg_wr(3'd0, 32'h0000_0009);
        stall = 1'b1;
        send(32'h21, 20, took); chk(took, "R4 message 1", 128'(took), 128'(1));
        send(32'h22, 20, took); chk(took, "R8 message 2", 128'(took), 128'(1));
        send(32'h23, 20, took); chk(took, "R4 message 3", 128'(took), 128'(1));
        stall = 1'b0;
        repeat (6) @(negedge clk);
        reg_expect(3'd6, 32'h30, "R5 wr_off after three records");
        chk(written.size() == 3, "R5 records written", 128'(written.size()), 128'(3));
        chk(irq, "R10 irq with unread records", 128'(irq), 128'(1));
        reg_wr(3'd5, 32'h30);
        #3 chk(!irq, "R10 irq after drain", 128'(irq), 128'(0));

        // R6: fill with stop-on-full, then free one slot
        reg_wr(3'd0, 32'h0000_001B);
        n_ok = 0;
        for (int k = 0; k < 2047; k++) begin
            send(32'h1000 + 32'(k), 10, took);
            if (took) n_ok++;
        end
        chk(n_ok == 2047, "R6 records before full", 128'(n_ok), 128'(2047));
        repeat (3) @(negedge clk);
        reg_expect(3'd6, 32'h20, "R5 wrapped wr_off");
        send(32'h99, 8, took);
        chk(!took, "R6 accepted while full", 128'(took), 128'(0));
        reg_wr(3'd5, 32'h40);
        send(32'h99, 8, took);
        chk(took, "R6 accepted after space freed", 128'(took), 128'(1));
        repeat (3) @(negedge clk);

        // R7: drop with overflow flag
        reg_wr(3'd0, 32'h0000_000B);
        send(32'hAA, 8, took);
        chk(took, "R7 dropped message acknowledged", 128'(took), 128'(1));
        repeat (3) @(negedge clk);
        reg_expect(3'd6, 32'h30, "R7 wr_off unchanged by drop");
        reg_expect(3'd0, 32'h8000_000B, "R7 overflow flag set");
        // clear and overflow in the same cycle: set wins
        @(negedge clk);
        reg_addr = 3'd0; reg_we = 1'b1; reg_wdata = 32'h8000_000B;
        msi_valid = 1'b1; msi_data = 32'hAB;
        @(negedge clk);
        reg_we = 1'b0; msi_valid = 1'b0;
        reg_expect(3'd0, 32'h8000_000B, "R7 set wins over clear");
        reg_wr(3'd0, 32'h8000_000B);
        reg_expect(3'd0, 32'h0000_000B, "R1 overflow write-one-clear");

        // R3: size field and read offset masking
        reg_wr(3'd0, 32'h0000_030B);
        reg_wr(3'd5, 32'h0003_FFFF);
        reg_expect(3'd5, 32'h0003_FFF0, "R3 rd_off mask at 256KB");
        send(32'h55, 8, took);
        repeat (3) @(negedge clk);
        reg_expect(3'd6, 32'h40, "R3 wr_off in large ring");
        reg_wr(3'd0, 32'h0000_000B);
        reg_wr(3'd5, 32'h0001_2345);
        reg_expect(3'd5, 32'h0000_2340, "R3 rd_off mask at 32KB");

        // R10 and R1: irq gated by enable, unmapped address
        reg_wr(3'd0, 32'h0000_0003);
        #3 chk(!irq, "R10 irq with enable clear", 128'(irq), 128'(0));
        reg_expect(3'd1, 32'd0, "R1 unmapped address");
        reg_expect(3'd0, 32'h0000_0003, "R1 control readback");

        repeat (4) @(negedge clk);
        summary();
        $finish;
    end

endmodule